// File: doc/BRIEF.md
# 100BASE-X Transmit Code-Group Framer

This block sits between a MAC transmit nibble interface and the 100 Mb/s line encoder. On every nibble clock it accepts a transmit-enable strobe, a 4-bit data nibble and a transmit-error flag. On every nibble clock it also emits one 5-bit code group. Between frames it sends the Idle code group.

When a frame begins, the two nibbles of the first preamble octet are replaced on the line by the stream-start pair J and K. All later nibbles pass through the 4B/5B table: the rest of the preamble, the SFD, the header, the payload and the CRC. When transmit-enable drops, the block closes the stream with the end pair T and R and then returns to Idle. Idle then fills the inter-frame gap. Scrambling, line coding and serialization happen downstream.

Every code group is written MSB first in this document, so `codeOut[4]` is the leftmost bit. The output is registered. The code group for the inputs sampled at one rising edge appears right after that edge.

Top module: `tx_code_framer`

## Requirements
- R1: While `rstN` is low, and after reset until a frame starts, `codeOut` is Idle = 11111.
- R2: While no frame is active and `txEn` is low, every code group is Idle = 11111.
- R3: The first cycle in which `txEn` is high while idle produces J = 11000. The next cycle produces K = 10001. The nibble values in these two cycles have no effect.
- R4: From the third cycle of a frame on, each nibble with `txEn` high is encoded as follows: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R5: In a frame of two or more nibbles, the first cycle with `txEn` low produces T = 01101. The cycle after that produces R = 00111. Idle follows if `txEn` stays low.
- R6: A frame in which `txEn` is high for only one cycle produces exactly J, K, T, R, in that order.
- R7: A cycle with `txEn` and `txErr` both high, from the third cycle of a frame on, produces Halt = 00100 in place of the encoded nibble. A `txErr` during the J or K cycle has no effect.
- R8: Nibbles presented while T or R is being produced are discarded. If `txEn` is high during those cycles, the next frame's J appears in the cycle right after R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| txEn | input | 1 | Frame strobe; high while the MAC presents frame nibbles |
| txData | input | 4 | Frame nibble |
| txErr | input | 1 | Requests Halt in place of the current data nibble |
| codeOut | output | 5 | Code group for the line, MSB first |

## Verification
Each code group is due one edge after the inputs that cause it. The bench drives a nibble on a falling edge, lets one rising edge pass, and compares `codeOut` on the next falling edge against the value that the requirements give for that frame slot. This covers J and K in the first two slots, the encoded nibble or Halt in later slots, T in the first low slot, and R one slot after T. The end pair and restarts are checked slot by slot, so a shift by a single cycle in any delimiter is reported.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [NIB_W-1:0]  nib_t;

  localparam code_t CODE_IDLE = 5'b11111;
  localparam code_t CODE_J    = 5'b11000;
  localparam code_t CODE_K    = 5'b10001;
  localparam code_t CODE_T    = 5'b01101;
  localparam code_t CODE_R    = 5'b00111;
  localparam code_t CODE_HALT = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SSD_K,
    ST_DATA,
    ST_ESD_T,
    ST_ESD_R
  } state_t;

  // strobes from control to datapath; none set means Idle
  typedef struct packed {
    logic selJ;
    logic selK;
    logic selT;
    logic selR;
    logic selHalt;
    logic selData;
  } sel_t;

  function automatic code_t enc4b5b(input nib_t n);
    code_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tx_framer_ctrl.sv
module tx_framer_ctrl
  import tx_framer_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic txEn,
  input  logic txErr,
  output sel_t sel
);
  state_t st, stNext;

  always_comb begin
    sel    = '0;
    stNext = st;
    case (st)
      ST_IDLE: begin
        if (txEn) begin
          sel.selJ = 1'b1;
          stNext   = ST_SSD_K;
        end
      end
      ST_SSD_K: begin
        sel.selK = 1'b1;
        stNext   = txEn ? ST_DATA : ST_ESD_T;
      end
      ST_DATA: begin
        if (txEn) begin
          if (txErr) sel.selHalt = 1'b1;
          else       sel.selData = 1'b1;
        end else begin
          sel.selT = 1'b1;
          stNext   = ST_ESD_R;
        end
      end
      ST_ESD_T: begin
        sel.selT = 1'b1;
        stNext   = ST_ESD_R;
      end
      ST_ESD_R: begin
        sel.selR = 1'b1;
        stNext   = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  // R4: at most one code source is selected per cycle
  p_one_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sel));

  // R5: an end-delimiter T is always followed by R
  p_t_then_r_state_r5: assert property (@(posedge clk) disable iff (!rstN)
    sel.selT |=> sel.selR);
endmodule

// File: rtl/tx_framer_dp.sv
module tx_framer_dp
  import tx_framer_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  sel_t  sel,
  input  nib_t  txData,
  output code_t codeOut
);
  code_t codeNext;

  always_comb begin
    codeNext = CODE_IDLE;
    if (sel.selJ)         codeNext = CODE_J;
    else if (sel.selK)    codeNext = CODE_K;
    else if (sel.selT)    codeNext = CODE_T;
    else if (sel.selR)    codeNext = CODE_R;
    else if (sel.selHalt) codeNext = CODE_HALT;
    else if (sel.selData) codeNext = enc4b5b(txData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) codeOut <= CODE_IDLE;
    else       codeOut <= codeNext;
  end

  // R7: Halt leaves the register only when the control asked for it
  p_halt_from_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CODE_HALT) |-> $past(sel.selHalt));
endmodule

// File: rtl/tx_code_framer.sv
module tx_code_framer
  import tx_framer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic [NIB_W-1:0] txData,
  input  logic             txErr,
  output logic [CODE_W-1:0] codeOut
);
  sel_t sel;

  tx_framer_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .txEn  (txEn),
    .txErr (txErr),
    .sel   (sel)
  );

  tx_framer_dp uDp (
    .clk     (clk),
    .rstN    (rstN),
    .sel     (sel),
    .txData  (txData),
    .codeOut (codeOut)
  );

  // R3: J is always followed by K
  p_j_then_k_r3: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CODE_J) |=> (codeOut == CODE_K));

  // R5: T is always followed by R
  p_t_then_r_r5: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CODE_T) |=> (codeOut == CODE_R));

  // R8: after R comes Idle or the next frame's J, depending on txEn
  p_after_r_r8: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CODE_R) |=> ($past(txEn) ? (codeOut == CODE_J) : (codeOut == CODE_IDLE)));

  // R2: Idle with txEn low stays Idle
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CODE_IDLE && !txEn) |=> (codeOut == CODE_IDLE));

  // R7: Halt only follows a cycle with txErr and txEn high
  p_halt_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CODE_HALT) |-> ($past(txErr) && $past(txEn)));
endmodule

// File: tb/tx_code_framer_test.sv
module tx_code_framer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEn = 1'b0;
  logic [3:0] txData = 4'h0;
  logic       txErr = 1'b0;
  logic [4:0] codeOut;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 1'b0;

  localparam logic [4:0] E_IDLE = 5'b11111;
  localparam logic [4:0] E_J    = 5'b11000;
  localparam logic [4:0] E_K    = 5'b10001;
  localparam logic [4:0] E_T    = 5'b01101;
  localparam logic [4:0] E_R    = 5'b00111;
  localparam logic [4:0] E_HALT = 5'b00100;

  always #5 clk = ~clk;

  tx_code_framer uut (
    .clk     (clk),
    .rstN    (rstN),
    .txEn    (txEn),
    .txData  (txData),
    .txErr   (txErr),
    .codeOut (codeOut)
  );

  function automatic logic [4:0] benchEnc(input logic [3:0] n);
    logic [4:0] t [16];
    t[0]  = 5'b11110; t[1]  = 5'b01001; t[2]  = 5'b10100; t[3]  = 5'b10101;
    t[4]  = 5'b01010; t[5]  = 5'b01011; t[6]  = 5'b01110; t[7]  = 5'b01111;
    t[8]  = 5'b10010; t[9]  = 5'b10011; t[10] = 5'b10110; t[11] = 5'b10111;
    t[12] = 5'b11010; t[13] = 5'b11011; t[14] = 5'b11100; t[15] = 5'b11101;
    return t[n];
  endfunction

  task automatic check(input logic [4:0] exp, input string req, input string what);
    testsRun++;
    if (codeOut !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: got %b expected %b", req, what, codeOut, exp);
    end
  endtask

  // drive one nibble slot and check the code group it produces one edge later
  task automatic driveCycle(input logic en, input logic [3:0] d, input logic er,
                            input logic [4:0] exp, input string req);
    txEn = en; txData = d; txErr = er;
    @(posedge clk);
    @(negedge clk);
    check(exp, req, "slot");
  endtask

  // errIdx < 0: no error; holdEn drives txEn high during the T/R cycles
  task automatic sendFrame(input int len, input int seed, input int errIdx,
                           input bit holdEn, input int gap);
    for (int i = 0; i < len; i++) begin
      logic [3:0] n;
      logic er;
      n  = 4'((seed + i * 7) % 16);
      er = (i == errIdx);
      if (i == 0)      driveCycle(1'b1, n, er, E_J, "R3");
      else if (i == 1) driveCycle(1'b1, n, er, E_K, "R3");
      else if (er)     driveCycle(1'b1, n, er, E_HALT, "R7");
      else             driveCycle(1'b1, n, er, benchEnc(n), "R4");
    end
    if (len == 1) begin
      driveCycle(1'b0, 4'h5, 1'b0, E_K, "R6");
      driveCycle(holdEn, 4'h9, 1'b0, E_T, "R6");
      driveCycle(holdEn, 4'h3, 1'b0, E_R, "R6");
    end else begin
      driveCycle(1'b0, 4'h5, 1'b0, E_T, "R5");
      driveCycle(holdEn, 4'hC, 1'b0, E_R, holdEn ? "R8" : "R5");
    end
    for (int g = 0; g < gap; g++)
      driveCycle(1'b0, 4'(g), 1'b0, E_IDLE, "R2");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with inputs active
    txEn = 1'b1; txData = 4'hA;
    repeat (3) @(negedge clk);
    check(E_IDLE, "R1", "during reset");
    txEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(E_IDLE, "R1", "after reset");

    // R2: quiet line with changing nibbles and error flag
    for (int i = 0; i < 6; i++)
      driveCycle(1'b0, 4'(i * 5), i[0], E_IDLE, "R2");

    // R4: one long frame covering every nibble value
    sendFrame(40, 0, -1, 1'b0, 4);

    // R6: one-nibble frame, R5: lengths swept
    for (int len = 1; len <= 24; len++)
      sendFrame(len, len * 3, -1, 1'b0, 3);

    // R7: Halt in data slots, and error ignored in J/K slots
    for (int e = 0; e < 8; e++)
      sendFrame(10, e, e, 1'b0, 2);

    // R8: txEn held during T/R, next frame starts right after R
    sendFrame(5, 1, -1, 1'b1, 0);
    sendFrame(1, 2, -1, 1'b1, 0);
    sendFrame(7, 4, 3, 1'b1, 0);
    sendFrame(3, 6, -1, 1'b0, 5);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule